// File: doc/BRIEF.md
# PWM Counter Sync and Start-Phase Loader

This block lines up one PWM counter with the other counters of a chain. A sync event comes either from an external sync pin or from a one-cycle software command. The pin first passes through a two-flop synchronizer and an optional polarity flip. It then goes through a digital noise filter, which can be bypassed. The filter samples at the system clock divided by a power of two. Its output changes level only after a programmable number of consecutive samples all disagree with the current level.

A rising edge of the filtered, polarity-corrected level is a sync event, as is a software sync pulse. One clock after the event, the block presents a load request to the counter. The request carries the programmed start phase and the count direction that applies after the load. The counter gives this request priority over its normal counting. The counter itself is outside the block and is seen only through this load port and two status inputs.

The block also drives a registered sync output for the next module in the chain. The source of that output is chosen by a two-bit select.

Top module: `phase_sync_loader`

## Requirements
- R1: While and after synchronous active-low reset, with no stimulus, `ld_valid` and `sync_out` are 0.
- R2: A one-cycle `sw_sync` pulse sampled at a clock edge makes `ld_valid` high for exactly the following cycle.
- R3: A load presents the `phase_val` and `phase_up` values present at the detection edge. `phase_up` = 1 means count up after the load and 0 means count down.
- R4: With the filter off (`filt_en` = 0), a rising pin edge (polarity-corrected) driven before clock edge c gives `ld_valid` after edge c+3. The path is two synchronizer flops, one level register and the load register.
- R5: With `sync_inv` = 1 the pin is inverted before edge detection. A falling pin edge then loads and a rising pin edge does not. Setting `sync_inv` while the pin idles low is itself a rising edge and loads two edges later.
- R6: With the filter on, the level changes only after `filt_cnt`+1 consecutive samples differ from it. A pulse seen by fewer samples produces no load.
- R7: The filter samples once every 2^`filt_div` clocks, with `filt_div` from 0 to 7 (divide by 1 to 128). A rising edge loads after between 3+`filt_cnt`·P and 2+P+`filt_cnt`·P edges, where P = 2^`filt_div`.
- R8: `sync_out` is registered and follows the select on the previous edge. Select 0 gives the sync event, so the pulse coincides with the load. Select 1 gives `cnt_zero`, select 2 gives `cnt_cmp_hit` and select 3 holds the output at 0.
- R9: A pin held high produces exactly one load.
- R10: A software pulse and a pin edge detected on the same edge produce a single load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_in | input | 1 | External sync pin, asynchronous |
| sync_inv | input | 1 | Invert the pin before filtering |
| filt_en | input | 1 | Enable the noise filter (0 = bypass) |
| filt_div | input | DIV_W (3) | Sample clock divider exponent |
| filt_cnt | input | FC_W (4) | Extra consecutive samples needed to change level |
| sw_sync | input | 1 | One-cycle software sync command |
| phase_val | input | PH_W (16) | Start phase to load |
| phase_up | input | 1 | Direction after load: 1 up, 0 down |
| cnt_zero | input | 1 | Counter is at zero |
| cnt_cmp_hit | input | 1 | Counter equals the odd-channel compare value |
| out_sel | input | 2 | Sync output source: 0 event, 1 zero, 2 compare, 3 off |
| ld_valid | output | 1 | Counter load request, one cycle |
| ld_value | output | PH_W (16) | Value to load |
| ld_up | output | 1 | Direction after load |
| sync_out | output | 1 | Sync output to the next module |

## Verification
Software pulses carrying different phase and direction pairs check that the captured payload comes from the detection edge. Pin edges with the filter bypassed pin down the exact four-edge latency. Several kinds of pin stimulus are applied with the filter on:
- short glitches, one sample below the threshold;
- long holds;
- the divider at 1, 4 and 128.

These show that the threshold counts consecutive samples and that the arrival window stretches with the sample period. Inverted-pin runs set a falling pin edge against a rising one, and a coincident software pulse and pin edge show that merging yields one load. Each output select is driven with both the chosen and an unchosen counter flag high, so a wrong route shows up.

// File: rtl/psl_pkg.sv
// Shared types for the sync and start-phase loader.
package psl_pkg;
    // Source of the chained sync output.
    typedef enum logic [1:0] {
        SO_EVENT = 2'd0,
        SO_ZERO  = 2'd1,
        SO_CMP   = 2'd2,
        SO_OFF   = 2'd3
    } so_sel_e;
endpackage

// File: rtl/psl_prescale.sv
// Sample strobe generator for the sync noise filter.
// Produces a one-cycle strobe every 2**div_sel clocks from a free-running
// counter. Assumes div_sel is at most 2**DIV_W-1; a change of div_sel takes
// effect at once, with no realignment of the strobe phase.
module psl_prescale #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel,
    output logic             strobe
);
    localparam int PS_W = (1 << DIV_W) - 1;

    logic [PS_W-1:0] ps_cnt;
    logic [PS_W-1:0] mask;

    // Low-bit mask of the selected period; shift past the top wraps to all ones.
    always_comb begin
        mask   = (PS_W'(1) << div_sel) - PS_W'(1);
        strobe = &(ps_cnt | ~mask);
    end

    // Free-running sample counter.
    always_ff @(posedge clk) begin
        if (!rst_n) ps_cnt <= '0;
        else        ps_cnt <= ps_cnt + PS_W'(1);
    end

    // Divide by one samples on every clock.
    p_div1_every_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (div_sel == '0) |-> strobe);

    // Any larger divider never strobes on two adjacent clocks.
    p_strobe_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && div_sel != '0) |=> (!strobe || div_sel == '0));
endmodule

// File: rtl/psl_filter.sv
// Sync pin conditioner: two-flop synchronizer, polarity flip, consecutive
// sample noise filter and rising edge detector.
// Assumes raw_in is asynchronous and that strobe comes from psl_prescale.
// With filt_en low the filter is bypassed and the level follows the
// polarity-corrected pin on every clock.
module psl_filter #(
    parameter int FC_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw_in,
    input  logic            invert,
    input  logic            filt_en,
    input  logic            strobe,
    input  logic [FC_W-1:0] need_cnt,
    output logic            level,
    output logic            rise
);
    logic            sy1, sy2;
    logic            pol;
    logic [FC_W-1:0] match;
    logic            prev;

    // Bring the pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sy1 <= 1'b0;
            sy2 <= 1'b0;
        end else begin
            sy1 <= raw_in;
            sy2 <= sy1;
        end
    end

    // Polarity-corrected pin.
    always_comb pol = sy2 ^ invert;

    // Level register: follow directly, or after need_cnt+1 differing samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= 1'b0;
            match <= '0;
        end else if (!filt_en) begin
            level <= pol;
            match <= '0;
        end else if (strobe) begin
            if (pol == level) begin
                match <= '0;
            end else if (match == need_cnt) begin
                level <= pol;
                match <= '0;
            end else begin
                match <= match + FC_W'(1);
            end
        end
    end

    // Previous level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= level;
    end

    always_comb rise = level & ~prev;

    // Between samples the filtered level cannot move.
    p_hold_between_samples_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en && !strobe) |=> $stable(level));

    // A sample agreeing with the level never changes it.
    p_agree_keeps_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en && strobe && pol == level) |=> $stable(level));
endmodule

// File: rtl/psl_syncout.sv
// Chained sync output selector.
// Registers one of: the local sync event, the counter-zero flag or the
// compare-hit flag; select 3 silences the output. Assumes the flags are
// synchronous to clk.
module psl_syncout
    import psl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] out_sel,
    input  logic       evt,
    input  logic       cnt_zero,
    input  logic       cnt_cmp_hit,
    output logic       sync_out
);
    so_sel_e sel_e;
    logic    nxt;

    // Decode the select into the next output bit.
    always_comb begin
        sel_e = so_sel_e'(out_sel);
        case (sel_e)
            SO_EVENT: nxt = evt;
            SO_ZERO:  nxt = cnt_zero;
            SO_CMP:   nxt = cnt_cmp_hit;
            default:  nxt = 1'b0;
        endcase
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_out <= 1'b0;
        else        sync_out <= nxt;
    end

    p_zero_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 2'd1) |=> (sync_out == $past(cnt_zero)));

    p_cmp_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 2'd2) |=> (sync_out == $past(cnt_cmp_hit)));

    p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 2'd3) |=> !sync_out);
endmodule

// File: rtl/phase_sync_loader.sv
// Sync and start-phase loader for one PWM counter.
// Merges the conditioned pin edge with a software sync pulse into one sync
// event, issues a one-cycle load request carrying the start phase and the
// direction one clock later, and drives the chained sync output.
// Assumes sw_sync is a synchronous one-cycle pulse and that the counter
// gives ld_valid priority over normal counting.
module phase_sync_loader #(
    parameter int PH_W  = 16,
    parameter int DIV_W = 3,
    parameter int FC_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    input  logic             sync_inv,
    input  logic             filt_en,
    input  logic [DIV_W-1:0] filt_div,
    input  logic [FC_W-1:0]  filt_cnt,
    input  logic             sw_sync,
    input  logic [PH_W-1:0]  phase_val,
    input  logic             phase_up,
    input  logic             cnt_zero,
    input  logic             cnt_cmp_hit,
    input  logic [1:0]       out_sel,
    output logic             ld_valid,
    output logic [PH_W-1:0]  ld_value,
    output logic             ld_up,
    output logic             sync_out
);
    logic strobe;
    logic pin_level;
    logic pin_rise;
    logic evt;

    psl_prescale #(.DIV_W(DIV_W)) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (filt_div),
        .strobe  (strobe)
    );

    psl_filter #(.FC_W(FC_W)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (sync_in),
        .invert   (sync_inv),
        .filt_en  (filt_en),
        .strobe   (strobe),
        .need_cnt (filt_cnt),
        .level    (pin_level),
        .rise     (pin_rise)
    );

    // Sync event: pin edge or software command, merged.
    always_comb evt = pin_rise | sw_sync;

    // Load request register: payload captured at detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid <= 1'b0;
            ld_value <= '0;
            ld_up    <= 1'b0;
        end else begin
            ld_valid <= evt;
            if (evt) begin
                ld_value <= phase_val;
                ld_up    <= phase_up;
            end
        end
    end

    psl_syncout u_syncout (
        .clk         (clk),
        .rst_n       (rst_n),
        .out_sel     (out_sel),
        .evt         (evt),
        .cnt_zero    (cnt_zero),
        .cnt_cmp_hit (cnt_cmp_hit),
        .sync_out    (sync_out)
    );

    p_load_follows_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> ld_valid);

    p_no_spurious_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> !ld_valid);

    p_phase_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (ld_value == $past(phase_val) && ld_up == $past(phase_up)));

    p_event_out_with_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 2'd0) |=> (sync_out == ld_valid));
endmodule

// File: tb/tb_phase_sync_loader.sv
`timescale 1ns/1ps
module tb_phase_sync_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_in = 1'b0;
    logic        sync_inv = 1'b0;
    logic        filt_en = 1'b0;
    logic [2:0]  filt_div = 3'd0;
    logic [3:0]  filt_cnt = 4'd0;
    logic        sw_sync = 1'b0;
    logic [15:0] phase_val = 16'h0;
    logic        phase_up = 1'b0;
    logic        cnt_zero = 1'b0;
    logic        cnt_cmp_hit = 1'b0;
    logic [1:0]  out_sel = 2'd0;
    logic        ld_valid;
    logic [15:0] ld_value;
    logic        ld_up;
    logic        sync_out;

    phase_sync_loader dut (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .sync_inv(sync_inv),
        .filt_en(filt_en), .filt_div(filt_div), .filt_cnt(filt_cnt),
        .sw_sync(sw_sync), .phase_val(phase_val), .phase_up(phase_up),
        .cnt_zero(cnt_zero), .cnt_cmp_hit(cnt_cmp_hit), .out_sel(out_sel),
        .ld_valid(ld_valid), .ld_value(ld_value), .ld_up(ld_up),
        .sync_out(sync_out)
    );

    always #4 clk = ~clk;

    typedef struct packed {
        int          lo;
        int          hi;
        logic [15:0] val;
        logic        up;
        logic        so;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    int   n_push = 0;
    int   n_seen = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(input int lo, input int hi);
        exp_t e;
        e.lo  = lo;
        e.hi  = hi;
        e.val = phase_val;
        e.up  = phase_up;
        e.so  = (out_sel == 2'd0);
        q.push_back(e);
        n_push++;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops each load against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !done && ld_valid) begin
            n_seen++;
            if (q.size() == 0) begin
                chk(1'b0, "R9", "unexpected load at cycle", cyc, -1);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(cyc >= e.lo && cyc <= e.hi, "R4/R7", "load cycle (lo bound shown)", cyc, e.lo);
                chk(ld_value == e.val, "R3", "ld_value", ld_value, e.val);
                chk(ld_up == e.up, "R3", "ld_up", ld_up, e.up);
                chk(sync_out == e.so, "R8", "sync_out with load", sync_out, e.so);
            end
        end
    end

    // Software pulse for one cycle; load expected on the next edge (R2).
    task automatic sw_pulse(input logic [15:0] v, input logic up);
        @(negedge clk);
        phase_val = v;
        phase_up  = up;
        sw_sync   = 1'b1;
        push(cyc + 1, cyc + 1);
        @(negedge clk);
        sw_sync = 1'b0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        int c0;
        // R1: reset state
        wait_n(4);
        chk(ld_valid == 1'b0, "R1", "ld_valid in reset", ld_valid, 0);
        chk(sync_out == 1'b0, "R1", "sync_out in reset", sync_out, 0);
        rst_n = 1'b1;
        wait_n(5);
        chk(ld_valid == 1'b0, "R1", "ld_valid after reset", ld_valid, 0);
        chk(sync_out == 1'b0, "R1", "sync_out after reset", sync_out, 0);

        // R2/R3: software sync with two payloads and both directions
        sw_pulse(16'h1234, 1'b1);
        wait_n(3);
        sw_pulse(16'hBEEF, 1'b0);
        wait_n(3);
        sw_pulse(16'h0001, 1'b1);
        sw_pulse(16'hFFFF, 1'b0);
        wait_n(3);

        // R4/R9: pin edge with filter bypassed, then held high
        phase_val = 16'h00A5; phase_up = 1'b1;
        @(negedge clk); c0 = cyc; sync_in = 1'b1; push(c0 + 4, c0 + 4);
        wait_n(20);
        chk(n_seen == n_push, "R9", "loads for held pin", n_seen, n_push);
        sync_in = 1'b0;
        wait_n(6);

        // R5: inversion
        phase_val = 16'h0C0C; phase_up = 1'b0;
        @(negedge clk); c0 = cyc; sync_inv = 1'b1; push(c0 + 2, c0 + 2);
        wait_n(8);
        @(negedge clk); sync_in = 1'b1;        // inverted: falling level, no load
        wait_n(10);
        chk(n_seen == n_push, "R5", "rising pin under inversion loads", n_seen - n_push, 0);
        phase_val = 16'h5A5A; phase_up = 1'b1;
        @(negedge clk); c0 = cyc; sync_in = 1'b0; push(c0 + 4, c0 + 4);
        wait_n(10);
        sync_inv = 1'b0;                         // level falls, no load
        wait_n(10);
        chk(n_seen == n_push, "R5", "loads after inversion tests", n_seen, n_push);

        // R6: filter, divide by 1, four samples needed
        filt_en = 1'b1; filt_div = 3'd0; filt_cnt = 4'd3;
        wait_n(5);
        @(negedge clk); sync_in = 1'b1;
        wait_n(3);
        sync_in = 1'b0;
        wait_n(15);
        chk(n_seen == n_push, "R6", "loads after short glitch", n_seen, n_push);
        phase_val = 16'h7777; phase_up = 1'b0;
        @(negedge clk); c0 = cyc; sync_in = 1'b1; push(c0 + 7, c0 + 7);
        wait_n(15);
        sync_in = 1'b0;
        wait_n(15);

        // R7: divide by 4, two samples needed
        filt_div = 3'd2; filt_cnt = 4'd1;
        wait_n(10);
        @(negedge clk); sync_in = 1'b1;
        wait_n(3);
        sync_in = 1'b0;
        wait_n(20);
        chk(n_seen == n_push, "R6", "loads after glitch at divide 4", n_seen, n_push);
        phase_val = 16'h3210; phase_up = 1'b1;
        @(negedge clk); c0 = cyc; sync_in = 1'b1; push(c0 + 8, c0 + 11);
        wait_n(20);
        sync_in = 1'b0;
        wait_n(20);

        // R7: divide by 128, one sample needed
        filt_div = 3'd7; filt_cnt = 4'd0;
        wait_n(10);
        phase_val = 16'h8001; phase_up = 1'b0;
        @(negedge clk); c0 = cyc; sync_in = 1'b1; push(c0 + 4, c0 + 131);
        wait_n(140);
        sync_in = 1'b0;
        wait_n(140);
        chk(n_seen == n_push, "R7", "loads at divide 128", n_seen, n_push);
        filt_en = 1'b0; filt_div = 3'd0;
        wait_n(5);

        // R10: software pulse on the same edge as a pin event
        phase_val = 16'h4242; phase_up = 1'b1;
        @(negedge clk); c0 = cyc; sync_in = 1'b1; push(c0 + 4, c0 + 4);
        wait_n(3);
        sw_sync = 1'b1;
        @(negedge clk);
        sw_sync = 1'b0;
        wait_n(5);
        chk(n_seen == n_push, "R10", "loads for merged event", n_seen, n_push);
        sync_in = 1'b0;
        wait_n(6);

        // R8: output select routes
        @(negedge clk); out_sel = 2'd1; cnt_zero = 1'b1;
        @(negedge clk);
        chk(sync_out == 1'b1, "R8", "zero route high", sync_out, 1);
        cnt_zero = 1'b0; cnt_cmp_hit = 1'b1;
        @(negedge clk);
        chk(sync_out == 1'b0, "R8", "zero route ignores compare", sync_out, 0);
        out_sel = 2'd2;
        @(negedge clk);
        chk(sync_out == 1'b1, "R8", "compare route high", sync_out, 1);
        cnt_cmp_hit = 1'b0; cnt_zero = 1'b1;
        @(negedge clk);
        chk(sync_out == 1'b0, "R8", "compare route ignores zero", sync_out, 0);
        out_sel = 2'd3; cnt_cmp_hit = 1'b1;
        @(negedge clk);
        chk(sync_out == 1'b0, "R8", "off route quiet", sync_out, 0);
        cnt_zero = 1'b0; cnt_cmp_hit = 1'b0;
        sw_pulse(16'h0F0F, 1'b1);               // load with quiet output
        wait_n(2);
        chk(sync_out == 1'b0, "R8", "off route after event", sync_out, 0);
        out_sel = 2'd0;
        wait_n(2);
        sw_pulse(16'hF0F0, 1'b0);               // load with event output
        wait_n(5);

        chk(q.size() == 0, "R9", "pending expected loads", q.size(), 0);
        chk(n_seen == n_push, "R9", "total loads", n_seen, n_push);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule